// File: doc/BRIEF.md
# Three-Channel Down-Counter with Snapshot Latches

This block holds three 16-bit down-counters behind a byte-wide host port. Addresses 0 to 2 reach the data port of channels 0 to 2, and address 3 is a write-only command port. A command byte either configures one channel or, when its top two bits are both set, asks for a snapshot of the count, the status, or both, for any set of channels at once. Counts are written and read one byte per access, in the byte order that each channel's access mode defines.

Snapshots are sticky. A latched count or status stays frozen until the host has read it out. While it is waiting to be read, further snapshot requests for the same item on that channel have no effect. The count latch and the status latch are handled independently of each other.

Each channel counts ticks from one of two sources. One is a shared internal tick, which is the system clock divided by a prescaler and which stops while `pwr_down` is high. The other is the channel's own external clock pin, which is synchronized and edge-detected. On each tick the count decrements. When the count reaches its terminal value it reloads and the channel output toggles.

Top module: `tmr_rb_unit`

## Requirements
- R1: After reset, `rdata` and `cnt_out` are 0. `rdata` is registered and shows the byte selected by a read in the clock cycle after `rd_en`. A read at address 3 returns 0.
- R2: A command byte whose bits 7:6 hold a channel number (0 to 2) configures that channel. Bits 5:4 set the access mode: 01 is low byte only, 10 is high byte only, 11 is low byte then high byte. Bits 3:1 are a stored counting-mode code, and bit 0 set selects the external clock. A configure byte with bits 5:4 equal to 00 is ignored. A valid configure byte releases both latches, resets both byte pointers, drives the output to 0, sets the null flag and halts counting until a count is loaded.
- R3: Count writes follow the access mode. Low-only loads {8'h00, byte}. High-only loads {byte, 8'h00}. Low-then-high stores the first byte and loads {second, first} on the second write. Loading clears the null flag and starts counting.
- R4: Count reads follow the access mode. In low-then-high mode a read pointer alternates between the low byte and the high byte, starting at the low byte.
- R5: A snapshot command has bits 7:6 = 11. Bit 5 low requests the count and bit 4 low requests the status. Bits 3, 2 and 1 select channels 2, 1 and 0. Bit 0 is ignored.
- R6: While a latched count is unread, further count snapshot requests for that channel are ignored. Reads return the first captured value, and the latch is released after its last byte has been read.
- R7: The status latch behaves like the count latch but independently of it. The status byte is {output, null flag, access mode[1:0], counting mode[2:0], clock select}, from bit 7 down to bit 0.
- R8: When both latches of a channel are held, the next read returns the status byte and releases only the status latch. The reads after it return the count bytes.
- R9: While armed, each tick decrements the count. A tick that finds the count at 1 reloads the loaded value and toggles the output, so the output half-period is the loaded value in ticks, with 0 meaning 65536.
- R10: The internal tick occurs once every PRESCALE system clocks. It is absent, and its divider is frozen, while `pwr_down` is high.
- R11: The external clock passes through a two-flop synchronizer. Each rising edge gives one tick, and this continues while `pwr_down` is high.
- R12: A count snapshot taken in the same cycle as a tick captures the count from before that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | 0-2 channel data, 3 command port |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Registered host read byte |
| ext_clk | input | NCH | Per-channel external clock inputs |
| pwr_down | input | 1 | Stops the internal tick while high |
| cnt_out | output | NCH | Per-channel toggling output |

## Verification
Two events can meet in one cycle: a count snapshot command and a count decrement. The bench provokes this by timing the snapshot write to land on the edge where a synchronized external clock edge takes effect. It then checks that the latch holds the value from before the decrement while the live count moves on. A bench-side reference model tracks every register and is compared with `rdata` and `cnt_out` on every clock, and directed literal checks cover latch priority, ignored requests, the byte order for each mode and the power-down gating.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LH   = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] cmode;
    logic       ext_sel;
  } chan_cfg_t;
endpackage

// File: rtl/tmr_rb_prescale.sv
module tmr_rb_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_down,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (!pwr_down) begin
      if (div_q == PW'(PRESCALE - 1)) begin
        div_q <= '0;
        tick  <= 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
        tick  <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  // R10: no internal tick follows a cycle in power-down
  assert_pd_gate_R10: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> !tick);
  // R10: ticks are isolated pulses when the divide ratio exceeds one
  assert_tick_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && PRESCALE > 1) |=> !tick);
endmodule

// File: rtl/tmr_rb_sync.sv
module tmr_rb_sync (
  input  logic clk,
  input  logic rst,
  input  logic ext_in,
  output logic rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= ext_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

  // R11: one tick per synchronized rising edge
  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/tmr_rb_chan.sv
module tmr_rb_chan
  import tmr_rb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  chan_cfg_t  cfg,
  input  logic       dat_we,
  input  logic [7:0] wdata,
  input  logic       dat_re,
  input  logic       rb_cnt,
  input  logic       rb_st,
  input  logic       tick_int,
  input  logic       tick_ext,
  output logic [7:0] rd_byte,
  output logic       out_q
);
  chan_cfg_t        cfg_q;
  logic [CNT_W-1:0] reload_q, count_q, cval_q;
  logic [7:0]       lowbuf_q, sval_q, stat_now;
  logic             null_q, armed_q, wptr_q, rptr_q, clat_q, slat_q;
  logic             tick, load_en;
  logic [CNT_W-1:0] load_val, rd_src;

  assign tick     = cfg_q.ext_sel ? tick_ext : tick_int;
  assign stat_now = {out_q, null_q, cfg_q.acc, cfg_q.cmode, cfg_q.ext_sel};

  always_comb begin
    load_en  = 1'b0;
    load_val = {8'h00, wdata};
    if (dat_we) begin
      case (cfg_q.acc)
        ACC_LO: load_en = 1'b1;
        ACC_HI: begin
          load_en  = 1'b1;
          load_val = {wdata, 8'h00};
        end
        ACC_LH: if (wptr_q) begin
          load_en  = 1'b1;
          load_val = {wdata, lowbuf_q};
        end
        default: load_en = 1'b0;
      endcase
    end
  end

  always_comb begin
    rd_src = clat_q ? cval_q : count_q;
    if (slat_q) rd_byte = sval_q;
    else begin
      case (cfg_q.acc)
        ACC_HI:  rd_byte = rd_src[15:8];
        ACC_LH:  rd_byte = rptr_q ? rd_src[15:8] : rd_src[7:0];
        default: rd_byte = rd_src[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '{acc: ACC_LH, cmode: 3'd0, ext_sel: 1'b0};
      reload_q <= '0;
      count_q  <= '0;
      cval_q   <= '0;
      lowbuf_q <= '0;
      sval_q   <= '0;
      out_q    <= 1'b0;
      null_q   <= 1'b1;
      armed_q  <= 1'b0;
      wptr_q   <= 1'b0;
      rptr_q   <= 1'b0;
      clat_q   <= 1'b0;
      slat_q   <= 1'b0;
    end else begin
      if (armed_q && tick) begin
        if (count_q == CNT_W'(1)) begin
          count_q <= reload_q;
          out_q   <= ~out_q;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      if (dat_we && cfg_q.acc == ACC_LH) begin
        wptr_q <= ~wptr_q;
        if (!wptr_q) lowbuf_q <= wdata;
      end
      if (load_en) begin
        reload_q <= load_val;
        count_q  <= load_val;
        armed_q  <= 1'b1;
        null_q   <= 1'b0;
      end
      if (dat_re) begin
        if (slat_q) slat_q <= 1'b0;
        else begin
          if (clat_q && (cfg_q.acc != ACC_LH || rptr_q)) clat_q <= 1'b0;
          if (cfg_q.acc == ACC_LH) rptr_q <= ~rptr_q;
        end
      end
      if (rb_cnt && !clat_q) begin
        clat_q <= 1'b1;
        cval_q <= count_q;
      end
      if (rb_st && !slat_q) begin
        slat_q <= 1'b1;
        sval_q <= stat_now;
      end
      if (cfg_we) begin
        cfg_q   <= cfg;
        wptr_q  <= 1'b0;
        rptr_q  <= 1'b0;
        armed_q <= 1'b0;
        null_q  <= 1'b1;
        out_q   <= 1'b0;
        clat_q  <= 1'b0;
        slat_q  <= 1'b0;
      end
    end
  end

  // R6: an unread count snapshot stays frozen
  assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (clat_q && !dat_re && !cfg_we) |=> (clat_q && $stable(cval_q)));
  // R7: an unread status snapshot stays frozen
  assert_st_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (slat_q && !dat_re && !cfg_we) |=> (slat_q && $stable(sval_q)));
  // R8: a read with both held releases status only
  assert_status_first_R8: assert property (@(posedge clk) disable iff (rst)
    (slat_q && clat_q && dat_re && !cfg_we) |=> (clat_q && !slat_q));
  // R9: terminal tick reloads and toggles
  assert_reload_R9: assert property (@(posedge clk) disable iff (rst)
    (armed_q && tick && count_q == CNT_W'(1) && !load_en && !cfg_we)
      |=> (count_q == $past(reload_q) && out_q != $past(out_q)));
  // R12: snapshot holds the pre-tick count
  assert_capture_R12: assert property (@(posedge clk) disable iff (rst)
    (rb_cnt && !clat_q && !cfg_we) |=> (cval_q == $past(count_q)));
endmodule

// File: rtl/tmr_rb_unit.sv
module tmr_rb_unit
  import tmr_rb_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int PRESCALE = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [1:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  input  logic [NCH-1:0] ext_clk,
  input  logic           pwr_down,
  output logic [NCH-1:0] cnt_out
);
  localparam logic [1:0] CMD_ADDR = 2'd3;

  logic           tick_int, is_cmd, is_rb;
  logic [NCH-1:0] cfg_we, dat_we, dat_re, rb_cnt, rb_st, tick_ext;
  logic [7:0]     rd_byte [NCH];
  logic [7:0]     sel_byte;
  chan_cfg_t      cfg_w;

  assign is_cmd = wr_en && addr == CMD_ADDR;
  assign is_rb  = is_cmd && wdata[7:6] == 2'b11;
  assign cfg_w  = '{acc: acc_e'(wdata[5:4]), cmode: wdata[3:1], ext_sel: wdata[0]};

  tmr_rb_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .tick(tick_int)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign cfg_we[i] = is_cmd && !is_rb && wdata[7:6] == 2'(i) && wdata[5:4] != 2'b00;
    assign dat_we[i] = wr_en && addr == 2'(i);
    assign dat_re[i] = rd_en && addr == 2'(i);
    assign rb_cnt[i] = is_rb && !wdata[5] && wdata[1+i];
    assign rb_st[i]  = is_rb && !wdata[4] && wdata[1+i];

    tmr_rb_sync u_sync (
      .clk(clk), .rst(rst), .ext_in(ext_clk[i]), .rise(tick_ext[i])
    );

    tmr_rb_chan u_chan (
      .clk(clk), .rst(rst), .cfg_we(cfg_we[i]), .cfg(cfg_w),
      .dat_we(dat_we[i]), .wdata(wdata), .dat_re(dat_re[i]),
      .rb_cnt(rb_cnt[i]), .rb_st(rb_st[i]), .tick_int(tick_int),
      .tick_ext(tick_ext[i]), .rd_byte(rd_byte[i]), .out_q(cnt_out[i])
    );
  end

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < NCH; i++)
      if (addr == 2'(i)) sel_byte = rd_byte[i];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= 8'h00;
    else if (rd_en) rdata <= sel_byte;
  end

  // R1: the command port reads back as zero
  assert_cmd_read_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == CMD_ADDR) |=> rdata == 8'h00);
  // R1: rdata only moves on a read
  assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/sim_tmr_rb_unit.sv
module sim_tmr_rb_unit;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0, pwr_down = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [2:0] ext_clk = 0, cnt_out;
  int checks = 0, failures = 0;
  bit done = 0;

  tmr_rb_unit #(.NCH(3), .PRESCALE(P)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .pwr_down(pwr_down),
    .cnt_out(cnt_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [1:0]  m_acc [3];
  logic [2:0]  m_cm [3];
  logic        m_ext [3], m_out [3], m_null [3], m_arm [3];
  logic        m_wp [3], m_rp [3], m_cl [3], m_sl [3];
  logic [15:0] m_rel [3], m_cnt [3], m_cval [3];
  logic [7:0]  m_low [3], m_sval [3];
  logic [7:0]  m_rdata;
  int          m_ps;
  logic        m_ti;
  logic [2:0]  m_s1, m_s2, m_s3;

  function automatic logic [7:0] mbyte(int c);
    logic [15:0] v;
    if (m_sl[c]) return m_sval[c];
    v = m_cl[c] ? m_cval[c] : m_cnt[c];
    if (m_acc[c] == 2'b10) return v[15:8];
    if (m_acc[c] == 2'b11) return m_rp[c] ? v[15:8] : v[7:0];
    return v[7:0];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 3; c++) begin
        m_acc[c] = 2'b11; m_cm[c] = 0; m_ext[c] = 0; m_out[c] = 0; m_null[c] = 1;
        m_arm[c] = 0; m_wp[c] = 0; m_rp[c] = 0; m_cl[c] = 0; m_sl[c] = 0;
        m_rel[c] = 0; m_cnt[c] = 0; m_cval[c] = 0; m_low[c] = 0; m_sval[c] = 0;
      end
      m_rdata = 0; m_ps = 0; m_ti = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      logic ti;
      logic [2:0] te;
      ti = m_ti;
      te = m_s2 & ~m_s3;
      if (rd_en) m_rdata = (addr < 3) ? mbyte(int'(addr)) : 8'h00;
      for (int c = 0; c < 3; c++) begin
        logic tk, pcl, psl;
        logic [15:0] pc;
        logic [7:0] pst;
        tk = m_ext[c] ? te[c] : ti;
        pc = m_cnt[c]; pcl = m_cl[c]; psl = m_sl[c];
        pst = {m_out[c], m_null[c], m_acc[c], m_cm[c], m_ext[c]};
        if (m_arm[c] && tk) begin
          if (pc == 1) begin m_cnt[c] = m_rel[c]; m_out[c] = ~m_out[c]; end
          else m_cnt[c] = pc - 1;
        end
        if (wr_en && addr == 2'(c)) begin
          logic ld;
          logic [15:0] lv;
          ld = 0; lv = 0;
          if (m_acc[c] == 2'b01) begin ld = 1; lv = {8'h00, wdata}; end
          else if (m_acc[c] == 2'b10) begin ld = 1; lv = {wdata, 8'h00}; end
          else if (m_acc[c] == 2'b11) begin
            if (!m_wp[c]) begin m_low[c] = wdata; m_wp[c] = 1; end
            else begin ld = 1; lv = {wdata, m_low[c]}; m_wp[c] = 0; end
          end
          if (ld) begin m_rel[c] = lv; m_cnt[c] = lv; m_arm[c] = 1; m_null[c] = 0; end
        end
        if (rd_en && addr == 2'(c)) begin
          if (psl) m_sl[c] = 0;
          else begin
            if (pcl && (m_acc[c] != 2'b11 || m_rp[c])) m_cl[c] = 0;
            if (m_acc[c] == 2'b11) m_rp[c] = ~m_rp[c];
          end
        end
        if (wr_en && addr == 3 && wdata[7:6] == 2'b11 && wdata[1+c]) begin
          if (!wdata[5] && !pcl) begin m_cl[c] = 1; m_cval[c] = pc; end
          if (!wdata[4] && !psl) begin m_sl[c] = 1; m_sval[c] = pst; end
        end
        if (wr_en && addr == 3 && wdata[7:6] == 2'(c) && wdata[5:4] != 0) begin
          m_acc[c] = wdata[5:4]; m_cm[c] = wdata[3:1]; m_ext[c] = wdata[0];
          m_wp[c] = 0; m_rp[c] = 0; m_arm[c] = 0; m_null[c] = 1; m_out[c] = 0;
          m_cl[c] = 0; m_sl[c] = 0;
        end
      end
      if (!pwr_down) begin
        if (m_ps == P - 1) begin m_ps = 0; m_ti = 1; end
        else begin m_ps = m_ps + 1; m_ti = 0; end
      end else m_ti = 0;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (rdata !== m_rdata) begin
        failures++;
        $display("FAIL R4 model rdata: actual=%h expected=%h", rdata, m_rdata);
      end
      checks++;
      if (cnt_out !== {m_out[2], m_out[1], m_out[0]}) begin
        failures++;
        $display("FAIL R9 model cnt_out: actual=%b expected=%b", cnt_out,
                 {m_out[2], m_out[1], m_out[0]});
      end
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rdata;
  endtask

  task automatic epulse(input int c);
    @(negedge clk); ext_clk[c] = 1;
    repeat (3) @(negedge clk);
    ext_clk[c] = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    int tg;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rdata, 0, "R1 reset rdata");
    chk(cnt_out, 0, "R1 reset cnt_out");
    rd(2'd3, v); chk(v, 0, "R1 command port read");

    // R2 R3 R4: low-then-high on external clock (held idle)
    wr(3, 8'h31); wr(0, 8'h34); wr(0, 8'h12);
    rd(0, v); chk(v, 8'h34, "R4 LH low");
    rd(0, v); chk(v, 8'h12, "R4 LH high");
    wr(3, 8'h51); wr(1, 8'hAB);
    rd(1, v); chk(v, 8'hAB, "R3 low-only load");
    wr(3, 8'hA1); wr(2, 8'hCD);
    rd(2, v); chk(v, 8'hCD, "R3 high-only load");

    // R5 R7: status snapshot of channel 1
    wr(3, 8'hE4);
    rd(1, v); chk(v, 8'h11, "R7 status byte ch1");

    // R6: count latch sticks, second request ignored
    wr(3, 8'hD2); epulse(0); epulse(0); wr(3, 8'hD2);
    rd(0, v); chk(v, 8'h34, "R6 latched low");
    rd(0, v); chk(v, 8'h12, "R6 latched high");
    rd(0, v); chk(v, 8'h32, "R6 live low after release");
    rd(0, v); chk(v, 8'h12, "R6 live high");

    // R8: both latched -> status first
    wr(3, 8'hC8);
    rd(2, v); chk(v, 8'h21, "R8 status first ch2");
    rd(2, v); chk(v, 8'hCD, "R8 count next ch2");
    // R7: pending count, new both-request latches status only
    wr(3, 8'hD4); epulse(1); wr(3, 8'hC4);
    rd(1, v); chk(v, 8'h11, "R7 status latched independently");
    rd(1, v); chk(v, 8'hAB, "R6 count request ignored");
    rd(1, v); chk(v, 8'hAA, "R6 live after release");

    // R12: snapshot in the tick cycle
    wr(3, 8'hB1); wr(2, 8'h05); wr(2, 8'h00);
    @(negedge clk); ext_clk[2] = 1;
    @(negedge clk);
    @(negedge clk); wr_en = 1; addr = 3; wdata = 8'hD8;
    @(negedge clk); wr_en = 0;
    repeat (3) @(negedge clk); ext_clk[2] = 0;
    rd(2, v); chk(v, 8'h05, "R12 pre-tick low");
    rd(2, v); chk(v, 8'h00, "R12 pre-tick high");
    rd(2, v); chk(v, 8'h04, "R12 live decremented");
    rd(2, v); chk(v, 8'h00, "R12 live high");

    // R9 R10: periodic on internal tick, half-period 3 ticks
    wr(3, 8'h50); wr(1, 8'h03);
    repeat (20) @(negedge clk);
    tg = 0; prev = cnt_out[1];
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (cnt_out[1] != prev) tg++;
      prev = cnt_out[1];
    end
    chk(16'(tg), 16'd10, "R9 toggles in 120 clocks");

    // R10 R11: power-down stops internal, external continues
    wr(3, 8'h11); wr(0, 8'h02);
    pwr_down = 1;
    repeat (3) @(negedge clk);
    begin
      int t0, t1;
      logic p0, p1;
      t0 = 0; t1 = 0; p0 = cnt_out[0]; p1 = cnt_out[1];
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (cnt_out[0] != p0) t0++;
        if (cnt_out[1] != p1) t1++;
        p0 = cnt_out[0]; p1 = cnt_out[1];
        ext_clk[0] = (k < 24) && ((k % 6) < 3);
      end
      chk(16'(t1), 16'd0, "R10 no internal ticks in power-down");
      chk(16'(t0), 16'd2, "R11 external ticks in power-down");
    end
    pwr_down = 0;

    // R2: configure byte with mode 00 ignored; R5 reserved bit 0
    wr(3, 8'h80);
    rd(2, v); chk(v, 8'h04, "R2 mode-00 ignored low");
    rd(2, v); chk(v, 8'h00, "R2 mode-00 ignored high");
    wr(3, 8'hE9);
    rd(2, v); chk(v, 8'h31, "R5 status with reserved bit set");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule